// File: doc/BRIEF.md
# Single-Lane Serial Flash Transaction Sequencer

This block runs one serial flash transaction on a single data lane, built from up to five phases that always come in a fixed order: an 8-bit opcode, an address, a run of dummy clocks, outgoing write data and incoming read data. Every phase except the opcode is switched on by its own length field, so one request port covers plain reads, fast reads with wait clocks, register writes and opcode-only commands. The block drives chip select, the serial clock and the outgoing data line in clock mode 0, and collects incoming bits into a result word.

A controller presents the opcode, address value and length, a dummy base count, write data with its length and the read length, then pulses `start` for one cycle. The dummy count actually used is the base count plus a compensation count, `dummy_extra`, which the system holds steady as a configuration value. The wait clocks are dropped whenever no read data is requested. When the last bit has been clocked, chip select rises, `done` pulses for one cycle and the received bits sit right-aligned in `rx_data`.

Top module: `sfl_phase_seq`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `mosi` is 0, and `busy` and `done` are 0.
- R2: The first 8 rising serial-clock edges of every transaction carry the opcode, most significant bit first.
- R3: An address length of 0 (up to ADDR_W) leaves out the address phase. Otherwise the low `addr_len` bits of `addr` follow the opcode, most significant bit first.
- R4: When the read length is nonzero, the address is followed by `dummy_base + dummy_extra` serial clocks, during which `mosi` is 0.
- R5: When the read length is 0, no dummy clocks are issued, whatever counts are programmed.
- R6: When the write length is nonzero (up to DATA_W), the low `wr_len` bits of `wr_data` go out after the dummy clocks, most significant bit first.
- R7: When the read length is nonzero (up to DATA_W), `miso` is sampled on each of the last `rd_len` rising edges. The first bit received lands in the highest used position of `rx_data`, the last in bit 0, and the unused upper bits are 0. `rx_data` is cleared when a transaction is accepted and holds its value while idle.
- R8: Clock mode 0 applies. `sclk` is low whenever `cs_n` is high, and `mosi` changes only while `sclk` is low.
- R9: `cs_n` stays low for the whole transaction, which has exactly 8 + address + dummy + write + read rising serial-clock edges.
- R10: A `start` pulse that arrives while `busy` is 1 is ignored. The running transaction completes unchanged, and no second transaction follows it.
- R11: `done` is a single-cycle pulse. It is raised in the cycle in which `cs_n` returns high, and `rx_data` already holds the result in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a transaction |
| cmd | input | 8 | Opcode byte |
| addr | input | ADDR_W | Address value, right-aligned |
| addr_len | input | $clog2(ADDR_W+1) | Address bits to send, 0 to skip |
| dummy_base | input | DUMMY_W | Base count of wait clocks |
| dummy_extra | input | DUMMY_W | Compensation wait clocks (configuration value) |
| wr_data | input | DATA_W | Outgoing data, right-aligned |
| wr_len | input | $clog2(DATA_W+1) | Outgoing data bits, 0 to skip |
| rd_len | input | $clog2(DATA_W+1) | Incoming data bits, 0 to skip |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_data | output | DATA_W | Received bits, right-aligned |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
A wrong phase register or phase-skip decision shows up at the ports within one serial bit time. The rising-edge count for the transaction comes out wrong, or the opcode, address and data fields land on the wrong clock numbers when the captured line is compared bit by bit. A bit counter that is off by one moves every following field and misaligns `rx_data`, and this is visible once `done` rises. Faults in the clock-edge bookkeeping show as `mosi` moving while `sclk` is high, or as `sclk` being high with chip select inactive, within the same system cycle.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_CMD  = 3'd1,
    PH_ADDR = 3'd2,
    PH_DUM  = 3'd3,
    PH_WR   = 3'd4,
    PH_RD   = 3'd5
  } phase_e;

  // Phase that follows p, given which optional phases are enabled.
  function automatic phase_e phase_after(phase_e p, logic has_addr, logic has_dum,
                                         logic has_wr, logic has_rd);
    phase_e n;
    n = PH_IDLE;
    if (has_rd && (p != PH_RD)) n = PH_RD;
    if (has_wr && (p inside {PH_CMD, PH_ADDR, PH_DUM})) n = PH_WR;
    if (has_dum && (p inside {PH_CMD, PH_ADDR})) n = PH_DUM;
    if (has_addr && (p == PH_CMD)) n = PH_ADDR;
    return n;
  endfunction

endpackage

// File: rtl/sfl_edge_gen.sv
module sfl_edge_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = (cnt_q == CW'(HALF - 1));
  assign tick_o = en_i && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)     cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sfl_rx_shift.sv
module sfl_rx_shift #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              sh_en;

  assign sh_en  = clr_i || sample_i;
  assign data_o = sh_q;

  always_comb begin
    if (clr_i) sh_d = '0;
    else       sh_d = {sh_q[DATA_W-2:0], miso_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sh_q <= '0;
    else if (sh_en) sh_q <= sh_d;
  end
endmodule

// File: rtl/sfl_phase_ctrl.sv
module sfl_phase_ctrl
  import sfl_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DUMMY_W = 8,
  parameter int ALW     = 6,
  parameter int LW      = 6,
  parameter int CNT_W   = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               tick_i,
  input  logic [7:0]         cmd_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [ALW-1:0]     addr_len_i,
  input  logic [DUMMY_W-1:0] dummy_base_i,
  input  logic [DUMMY_W-1:0] dummy_extra_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [LW-1:0]      wlen_i,
  input  logic [LW-1:0]      rlen_i,
  output logic               busy_o,
  output logic               accept_o,
  output logic               sample_o,
  output logic               done_o,
  output logic               sclk_o,
  output logic               mosi_o
);
  localparam int AIW = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam int DIW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  // Latched request
  logic [7:0]         cmd_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [ALW-1:0]     alen_q;
  logic [DUMMY_W:0]   dum_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LW-1:0]      wlen_q, rlen_q;
  logic [DUMMY_W:0]   dum_sum;

  // Sequencing state
  phase_e             ph_q, ph_d, ph_nx;
  logic [CNT_W-1:0]   bit_q, bit_d;
  logic               sclk_q, sclk_d;
  logic               done_q, done_d;
  logic               has_addr, has_dum, has_wr, has_rd;

  assign dum_sum  = {1'b0, dummy_base_i} + {1'b0, dummy_extra_i};
  assign accept_o = start_i && (ph_q == PH_IDLE);
  assign busy_o   = (ph_q != PH_IDLE);
  assign sclk_o   = sclk_q;
  assign done_o   = done_q;
  assign sample_o = tick_i && !sclk_q && (ph_q == PH_RD);

  assign has_addr = (alen_q != '0);
  assign has_wr   = (wlen_q != '0);
  assign has_rd   = (rlen_q != '0);
  assign has_dum  = (dum_q != '0) && has_rd;
  assign ph_nx    = phase_after(ph_q, has_addr, has_dum, has_wr, has_rd);

  function automatic logic [CNT_W-1:0] last_idx(phase_e p);
    logic [CNT_W-1:0] l;
    case (p)
      PH_ADDR: l = CNT_W'(alen_q);
      PH_DUM:  l = CNT_W'(dum_q);
      PH_WR:   l = CNT_W'(wlen_q);
      PH_RD:   l = CNT_W'(rlen_q);
      default: l = CNT_W'(8);
    endcase
    return l - CNT_W'(1);
  endfunction

  always_comb begin
    case (ph_q)
      PH_CMD:  mosi_o = cmd_q[bit_q[2:0]];
      PH_ADDR: mosi_o = addr_q[bit_q[AIW-1:0]];
      PH_WR:   mosi_o = wdata_q[bit_q[DIW-1:0]];
      default: mosi_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      alen_q  <= '0;
      dum_q   <= '0;
      wdata_q <= '0;
      wlen_q  <= '0;
      rlen_q  <= '0;
    end else if (accept_o) begin
      cmd_q   <= cmd_i;
      addr_q  <= addr_i;
      alen_q  <= addr_len_i;
      dum_q   <= dum_sum;
      wdata_q <= wdata_i;
      wlen_q  <= wlen_i;
      rlen_q  <= rlen_i;
    end
  end

  always_comb begin
    ph_d   = ph_q;
    bit_d  = bit_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    if (accept_o) begin
      ph_d   = PH_CMD;
      bit_d  = CNT_W'(7);
      sclk_d = 1'b0;
    end else if (busy_o && tick_i) begin
      if (!sclk_q) begin
        sclk_d = 1'b1;
      end else begin
        sclk_d = 1'b0;
        if (bit_q != '0) begin
          bit_d = bit_q - CNT_W'(1);
        end else begin
          ph_d  = ph_nx;
          bit_d = last_idx(ph_nx);
          if (ph_nx == PH_IDLE) done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      bit_q  <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/sfl_phase_seq.sv
module sfl_phase_seq #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int DUMMY_W = 8,
  parameter int HALF    = 2,
  localparam int ALW    = $clog2(ADDR_W + 1),
  localparam int LW     = $clog2(DATA_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [7:0]         cmd,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [ALW-1:0]     addr_len,
  input  logic [DUMMY_W-1:0] dummy_base,
  input  logic [DUMMY_W-1:0] dummy_extra,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [LW-1:0]      wr_len,
  input  logic [LW-1:0]      rd_len,
  output logic               busy,
  output logic               done,
  output logic [DATA_W-1:0]  rx_data,
  output logic               cs_n,
  output logic               sclk,
  output logic               mosi,
  input  logic               miso
);
  localparam int W_A   = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
  localparam int W_D   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int W_AD  = (W_A > W_D) ? W_A : W_D;
  localparam int W_DM  = DUMMY_W + 1;
  localparam int W_M   = (W_AD > W_DM) ? W_AD : W_DM;
  localparam int CNT_W = (W_M > 3) ? W_M : 3;

  logic tick, accept, sample;

  sfl_edge_gen #(.HALF(HALF)) i_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (busy),
    .tick_o (tick)
  );

  sfl_phase_ctrl #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .DUMMY_W (DUMMY_W),
    .ALW (ALW), .LW (LW), .CNT_W (CNT_W)
  ) i_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .tick_i        (tick),
    .cmd_i         (cmd),
    .addr_i        (addr),
    .addr_len_i    (addr_len),
    .dummy_base_i  (dummy_base),
    .dummy_extra_i (dummy_extra),
    .wdata_i       (wr_data),
    .wlen_i        (wr_len),
    .rlen_i        (rd_len),
    .busy_o        (busy),
    .accept_o      (accept),
    .sample_o      (sample),
    .done_o        (done),
    .sclk_o        (sclk),
    .mosi_o        (mosi)
  );

  sfl_rx_shift #(.DATA_W(DATA_W)) i_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (accept),
    .sample_i (sample),
    .miso_i   (miso),
    .data_o   (rx_data)
  );

  assign cs_n = !busy;
endmodule

// File: rtl/sfl_phase_seq_chk.sv
module sfl_phase_seq_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic [DATA_W-1:0] rx_data
);
  assert_idle_clk_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_hold_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_at_cs_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(!cs_n)));

  assert_rx_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(rx_data));

  assert_busy_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !done) |=> (busy || done));

  assert_cs_tracks_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (busy && !sclk));
endmodule

bind sfl_phase_seq sfl_phase_seq_chk #(.DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .cs_n    (cs_n),
  .sclk    (sclk),
  .mosi    (mosi),
  .rx_data (rx_data)
);

// File: tb/test_sfl_phase_seq.sv
module test_sfl_phase_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  cmd;
  logic [31:0] addr;
  logic [5:0]  addr_len;
  logic [7:0]  dummy_base, dummy_extra;
  logic [31:0] wr_data;
  logic [5:0]  wr_len, rd_len;
  logic        busy, done, cs_n, sclk, mosi, miso;
  logic [31:0] rx_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [511:0] cap;
  logic [511:0] resp;
  int rise_cnt;
  int done_cnt;
  int mode_viol;
  logic prev_sclk, prev_mosi;

  always #2 clk = ~clk;

  sfl_phase_seq i_sfl_phase_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .addr(addr),
    .addr_len(addr_len), .dummy_base(dummy_base), .dummy_extra(dummy_extra),
    .wr_data(wr_data), .wr_len(wr_len), .rd_len(rd_len), .busy(busy),
    .done(done), .rx_data(rx_data), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso)
  );

  // Responder: bit k of resp is presented for rising edge number k.
  assign miso = cs_n ? 1'b0 : resp[rise_cnt[8:0]];

  always @(posedge sclk) begin
    if (!cs_n) begin
      cap[rise_cnt[8:0]] <= mosi;
      rise_cnt <= rise_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (sclk && prev_sclk && (mosi !== prev_mosi)) mode_viol <= mode_viol + 1;
      if (cs_n && sclk) mode_viol <= mode_viol + 1;
      if (done) begin
        done_cnt <= done_cnt + 1;
        if (!cs_n) mode_viol <= mode_viol + 1;
      end
    end
    prev_sclk <= sclk;
    prev_mosi <= mosi;
  end

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic longint seg(int from, int len);
    longint v = 0;
    for (int i = 0; i < len; i++) v = (v << 1) | longint'(cap[from + i]);
    return v;
  endfunction

  task automatic run(input logic [7:0] c, input logic [31:0] a, input int al,
                     input int db, input int de, input logic [31:0] wd,
                     input int wl, input int rl, input int poke_at, input string tag);
    int dm, pre, total, wait_cyc, dz;
    longint exp_rx;
    dm = (rl != 0) ? db + de : 0;
    total = 8 + al + dm + wl + rl;
    resp = {16{32'h5A3C_96E1 ^ {c, c, c, c}}};
    @(negedge clk);
    cap = '0; rise_cnt = 0; done_cnt = 0; mode_viol = 0;
    cmd = c; addr = a; addr_len = 6'(al); dummy_base = 8'(db); dummy_extra = 8'(de);
    wr_data = wd; wr_len = 6'(wl); rd_len = 6'(rl); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cmd = 8'h00; addr = '0; wr_data = '0;
    wait_cyc = 0;
    while (!done && wait_cyc < 5000) begin
      if (poke_at != 0 && wait_cyc == poke_at) begin
        // R10: a second request mid-transaction must be ignored
        cmd = 8'hFF; addr = 32'hFFFF_FFFF; addr_len = 6'd8; wr_len = 6'd4; rd_len = 6'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cyc++;
      end else begin
        @(negedge clk);
        wait_cyc++;
      end
    end
    check("R11", {tag, " done seen"}, longint'(done), 1);
    check("R11", {tag, " cs_n high at done"}, longint'(cs_n), 1);
    exp_rx = 0;
    pre = 8 + al + dm + wl;
    for (int i = 0; i < rl; i++) exp_rx = (exp_rx << 1) | longint'(resp[pre + i]);
    check("R7", {tag, " rx_data at done"}, longint'(rx_data), exp_rx);
    repeat (40) @(negedge clk);
    check("R9", {tag, " rising edges"}, longint'(rise_cnt), longint'(total));
    check("R2", {tag, " opcode bits"}, seg(0, 8), longint'(c));
    if (al != 0)
      check("R3", {tag, " address bits"}, seg(8, al), longint'(a) & ((64'd1 << al) - 1));
    dz = 0;
    for (int i = 0; i < dm; i++) dz += int'(cap[8 + al + i]);
    check("R4", {tag, " mosi low in dummy"}, longint'(dz), 0);
    if (wl != 0)
      check("R6", {tag, " write bits"}, seg(8 + al + dm, wl), longint'(wd) & ((64'd1 << wl) - 1));
    check("R8", {tag, " mode 0 violations"}, longint'(mode_viol), 0);
    check("R11", {tag, " done pulses"}, longint'(done_cnt), 1);
    check("R10", {tag, " idle after"}, longint'(busy), 0);
    check("R7", {tag, " rx_data held idle"}, longint'(rx_data), exp_rx);
  endtask

  task automatic t_reset;
    check("R1", "cs_n reset", longint'(cs_n), 1);
    check("R1", "sclk reset", longint'(sclk), 0);
    check("R1", "mosi reset", longint'(mosi), 0);
    check("R1", "busy reset", longint'(busy), 0);
    check("R1", "done reset", longint'(done), 0);
  endtask

  task automatic t_plain_read;   run(8'h03, 32'h00AB_CDEF, 24, 0, 0, 32'h0, 0, 32, 0, "R2/R3 read32"); endtask
  task automatic t_fast_read;    run(8'h0B, 32'h0012_3456, 24, 8, 2, 32'h0, 0, 16, 0, "R4 fastread"); endtask
  task automatic t_write_nodum;  run(8'h02, 32'h0076_5432, 24, 8, 1, 32'hDEAD_BEEF, 32, 0, 0, "R5/R6 write"); endtask
  task automatic t_cmd_only;     run(8'h06, 32'hFFFF_FFFF, 0, 5, 3, 32'h0, 0, 0, 0, "R3/R5 cmdonly"); endtask
  task automatic t_status;       run(8'h05, 32'h0, 0, 0, 0, 32'h0, 0, 8, 0, "R7 status8"); endtask
  task automatic t_full_mix;     run(8'hA7, 32'h8000_0001, 32, 1, 1, 32'h0000_0135, 9, 5, 0, "R6/R7 allphases"); endtask
  task automatic t_busy_ignore;  run(8'h9F, 32'h0, 0, 0, 0, 32'h0, 0, 24, 30, "R10 busystart"); endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; cmd = '0; addr = '0; addr_len = '0;
    dummy_base = '0; dummy_extra = '0; wr_data = '0; wr_len = '0; rd_len = '0;
    cap = '0; resp = '0; rise_cnt = 0; done_cnt = 0; mode_viol = 0;
    prev_sclk = 1'b0; prev_mosi = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain_read();
    t_fast_read();
    t_write_nodum();
    t_cmd_only();
    t_status();
    t_full_mix();
    t_busy_ignore();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule